// File: doc/BRIEF.md
# Level-selectable multicarrier PWM generator

This block produces the 24 gate signals for a three-phase diode-clamped inverter whose legs each hold eight switches arranged as a five-level leg. A level select input lets the same switches run as a five-level, three-level or two-level inverter. In the lower-level modes the leg switches are grouped in pairs or in fours, and each group is driven by one comparison. One triangular up/down counter is shared by all carrier bands and all phases. The bands are stacked on top of each other by offsetting that counter. A selectable disposition mirrors the count in chosen bands.

Each phase compares the stacked carriers with its own sinusoidal reference, which is sampled once per carrier period. The reference comes from a computed 256-step sine and is scaled by an 8-bit modulation index. Phases B and C read the sine one third and two thirds of a cycle ahead of phase A. Level, disposition and modulation index are taken in only at the start of a carrier period. An unsupported level code forces every leg into its safe state and raises an error output.

Top module: `mlpwm_top`

## Requirements
- R1: While reset is high, and after the first rising edge with reset low (edge 0), every upper gate is 0, every lower gate is 1 and err_o is 0.
- R2: With level code 2'b00 (five-level), four carriers c_k = -2H + k*H + t_k are used, for k = 0..3, where H is the parameter HALF and t_k is the band's count. Upper gate bit ph*4+k (ph 0 = A, 1 = B, 2 = C) is 1 exactly when the phase reference is strictly greater than c_k. Lower gate bit ph*4+k is always the inverse of upper bit ph*4+k.
- R3: With level code 2'b01 (three-level), two carriers c_j = -2H + j*2H + 2*t_j are used, for j = 0..1. Upper bits k = 0 and 1 follow carrier 0 together, and bits k = 2 and 3 follow carrier 1 together.
- R4: With level code 2'b10 (two-level), one carrier c = -2H + 4*t is used, and all four upper bits of a phase switch together.
- R5: The count t is a triangle 0, 1, ..., H, H-1, ..., 1, repeating with a period of 2H clocks. After edge e (e >= 1), the outputs reflect the count value at position (e-1) mod 2H of that sequence. Within a phase, upper bit k+1 is never 1 while upper bit k is 0.
- R6: Disposition code 2'b00 uses t_k = t in every band. Code 2'b01 mirrors the count (t_k = H - t) in every band that lies below zero. Code 2'b10 mirrors the count in the odd bands. Code 2'b11 behaves like 2'b00.
- R7: Level, disposition and modulation index are captured only at the edges where the count is 0, that is, edge 0 and every 2H edges after it. Changes between those edges have no effect until the next capture.
- R8: Once level code 2'b11 is captured, every upper gate is 0, every lower gate is 1 and err_o is 1 until a valid code is captured.
- R9: For carrier period p, the phase A reference is floor(s(p mod 256) * mi * 2H / 32768), where s is a signed sine of amplitude 127 over 256 steps. Phase B uses step p+85 and phase C uses step p+171. With mi = 0 the reference is exactly 0.
- R10: With mi = 255 in five-level mode, the total count of upper-on clocks in a period sweeps from 0 at the sine trough (step 192) up to 117 at the crest (step 64) when H = 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Level select: 00 five, 01 three, 10 two, 11 unsupported |
| disp_i | input | 2 | Carrier disposition: 00 in phase, 01 lower half mirrored, 10 alternate bands mirrored, 11 as 00 |
| mi_i | input | 8 | Modulation index, 0 to 255 |
| gate_hi_o | output | 12 | Upper switch gates, bit ph*4+k |
| gate_lo_o | output | 12 | Lower switch gates, complement of the upper ones |
| err_o | output | 1 | Unsupported level code captured |

## Verification
The assertions take for granted that the level code seen at the gate stage is the one captured at the last period start. They also assume that HALF is at least 2, so the triangle has a distinct top and bottom. The stack-order and grouping checks depend only on the bands being stacked, so they hold for any reference the sine produces. The bench holds mi at zero while it walks the level and disposition table, which makes the reference exactly zero and every gate value computable from the count. It changes inputs just after a falling edge and part-way through a period, so the capture point can be seen. It then runs a fresh sine sweep at full index and compares whole-period on-counts between the phases.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  localparam int NPH     = 3;
  localparam int NSW     = 4;
  localparam int SINE_PW = 8;
  localparam int SINE_AMP = 127;
  localparam int SCALE_SH = 15;

  typedef enum logic [1:0] {
    LVL5    = 2'b00,
    LVL3    = 2'b01,
    LVL2    = 2'b10,
    LVL_BAD = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    DSP_PD   = 2'b00,
    DSP_POD  = 2'b01,
    DSP_APOD = 2'b10,
    DSP_ALT  = 2'b11
  } dsp_e;

  // log2 of the number of switches that share one comparison
  function automatic int grp_shift(input lvl_e m);
    case (m)
      LVL3:    return 1;
      LVL2:    return 2;
      default: return 0;
    endcase
  endfunction

  // parabolic sine over 2**SINE_PW steps, amplitude SINE_AMP
  function automatic int sine_pt(input logic [SINE_PW-1:0] ph);
    int q;
    int x;
    int mag;
    q   = int'(ph[SINE_PW-3:0]);
    x   = ph[SINE_PW-2] ? (2**(SINE_PW-2)) - q : q;
    mag = (x * ((2**(SINE_PW-1)) - x) * SINE_AMP) / (2**(2*SINE_PW-4));
    return ph[SINE_PW-1] ? -mag : mag;
  endfunction

  // reference in carrier units: s * mi * 2H / 2**SCALE_SH, floored
  function automatic int scale_ref(input int s, input logic [7:0] mi, input int half);
    int prod;
    prod = s * int'(mi) * 2 * half;
    return prod >>> SCALE_SH;
  endfunction

  // carrier value of one stacked band for the given grouping
  function automatic int band_carrier(input int band, input int sh, input dsp_e d,
                                      input int t, input int half);
    int g;
    int bh;
    bit mir;
    int tt;
    g  = 1 << sh;
    bh = g * half;
    case (d)
      DSP_POD:  mir = (band * bh) < (2 * half);
      DSP_APOD: mir = band[0];
      default:  mir = 1'b0;
    endcase
    tt = mir ? (half - t) : t;
    return (band * bh) - (2 * half) + (g * tt);
  endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int HALF = 255,
  parameter int CW   = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          boundary_o
);

  logic [CW-1:0] cnt_q;
  logic          rising_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(HALF - 1)) rising_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) rising_q <= 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign boundary_o = (cnt_q == '0);

endmodule

// File: rtl/mlpwm_refgen.sv
module mlpwm_refgen
  import mlpwm_pkg::*;
#(
  parameter int HALF = 255,
  parameter int STEP = 1,
  parameter int RW   = $clog2(HALF + 1) + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic [7:0]        mi_i,
  output logic [NPH*RW-1:0] ref_o
);

  logic [SINE_PW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (sample_i) acc_q <= acc_q + SINE_PW'(STEP);
  end

  for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
    localparam int OFF = (ph * (2**SINE_PW) + 1) / 3;
    logic [SINE_PW-1:0]   idx;
    logic signed [RW-1:0] ref_q;

    assign idx = acc_q + OFF[SINE_PW-1:0];

    always_ff @(posedge clk) begin
      if (rst) ref_q <= '0;
      else if (sample_i) ref_q <= RW'(scale_ref(sine_pt(idx), mi_i, HALF));
    end

    assign ref_o[ph*RW +: RW] = ref_q;
  end

endmodule

// File: rtl/mlpwm_leg.sv
module mlpwm_leg
  import mlpwm_pkg::*;
#(
  parameter int HALF = 255,
  parameter int CW   = $clog2(HALF + 1),
  parameter int RW   = CW + 3
) (
  input  lvl_e                 mode_i,
  input  dsp_e                 disp_i,
  input  logic [CW-1:0]        cnt_i,
  input  logic signed [RW-1:0] ref_i,
  output logic [NSW-1:0]       up_o
);

  int sh;
  int refv;
  int cntv;

  assign sh   = grp_shift(mode_i);
  assign refv = int'(ref_i);
  assign cntv = int'(cnt_i);

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    int band;
    int car;
    assign band    = k >> sh;
    assign car     = band_carrier(band, sh, disp_i, cntv, HALF);
    assign up_o[k] = refv > car;
  end

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int HALF = 255,
  parameter int STEP = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           disp_i,
  input  logic [7:0]           mi_i,
  output logic [NPH*NSW-1:0]   gate_hi_o,
  output logic [NPH*NSW-1:0]   gate_lo_o,
  output logic                 err_o
);

  localparam int CW = $clog2(HALF + 1);
  localparam int RW = CW + 3;
  localparam int NG = NPH * NSW;

  logic [CW-1:0]     cnt;
  logic              boundary;
  logic [NPH*RW-1:0] refs;
  logic [CW-1:0]     cnt_d;
  lvl_e              mode_q;
  dsp_e              disp_q;
  lvl_e              md_g;
  logic              armed_q;
  logic              mode_bad;
  logic              run;
  logic [NG-1:0]     leg_up;
  logic [NG-1:0]     gate_up_q;
  logic [NG-1:0]     gate_dn_q;
  logic              err_q;

  mlpwm_carrier #(.HALF(HALF)) u_car (
    .clk        (clk),
    .rst        (rst),
    .cnt_o      (cnt),
    .boundary_o (boundary)
  );

  mlpwm_refgen #(.HALF(HALF), .STEP(STEP), .RW(RW)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .sample_i (boundary),
    .mi_i     (mi_i),
    .ref_o    (refs)
  );

  for (genvar ph = 0; ph < NPH; ph++) begin : g_leg
    mlpwm_leg #(.HALF(HALF), .CW(CW), .RW(RW)) u_leg (
      .mode_i (mode_q),
      .disp_i (disp_q),
      .cnt_i  (cnt_d),
      .ref_i  (refs[ph*RW +: RW]),
      .up_o   (leg_up[ph*NSW +: NSW])
    );
  end

  assign mode_bad = (mode_q == LVL_BAD);
  assign run      = armed_q && !mode_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_d     <= '0;
      mode_q    <= LVL5;
      disp_q    <= DSP_PD;
      armed_q   <= 1'b0;
      md_g      <= LVL5;
      gate_up_q <= '0;
      gate_dn_q <= '1;
      err_q     <= 1'b0;
    end else begin
      cnt_d <= cnt;
      if (boundary) begin
        mode_q  <= lvl_e'(mode_i);
        disp_q  <= dsp_e'(disp_i);
        armed_q <= 1'b1;
      end
      md_g      <= mode_q;
      gate_up_q <= run ? leg_up : '0;
      gate_dn_q <= run ? ~leg_up : '1;
      err_q     <= armed_q && mode_bad;
    end
  end

  assign gate_hi_o = gate_up_q;
  assign gate_lo_o = gate_dn_q;
  assign err_o     = err_q;

endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk
  import mlpwm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               boundary,
  input lvl_e               mode_q,
  input lvl_e               md_g,
  input logic               err,
  input logic [NPH*NSW-1:0] up,
  input logic [NPH*NSW-1:0] dn
);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(mode_q));

  // R8
  err_safe_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (up == '0) && (dn == '1));

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    for (genvar k = 0; k < NSW - 1; k++) begin : g_k
      // R5
      stack_order_chk: assert property (@(posedge clk) disable iff (rst)
        up[p*NSW+k+1] |-> up[p*NSW+k]);
    end

    // R3
    pair_group_chk: assert property (@(posedge clk) disable iff (rst)
      (md_g == LVL3 && !err) |->
        (up[p*NSW] == up[p*NSW+1]) && (up[p*NSW+2] == up[p*NSW+3]));

    // R4
    quad_group_chk: assert property (@(posedge clk) disable iff (rst)
      (md_g == LVL2 && !err) |->
        ($countones(up[p*NSW +: NSW]) == 0) || ($countones(up[p*NSW +: NSW]) == NSW));
  end

endmodule

bind mlpwm_top mlpwm_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .boundary (boundary),
  .mode_q   (mode_q),
  .md_g     (md_g),
  .err      (err_q),
  .up       (gate_up_q),
  .dn       (gate_dn_q)
);

// File: tb/mlpwm_top_test.sv
`timescale 1ns/1ps
module mlpwm_top_test;

  localparam int H   = 15;
  localparam int PER = 2 * H;
  localparam int NPER_SWEEP = 429;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  disp_i = 2'b00;
  logic [7:0]  mi_i = 8'd0;
  logic [11:0] up;
  logic [11:0] dn;
  logic        err;

  int  nchk = 0;
  int  nfail = 0;
  int  e = -1;
  logic [1:0] lm = 2'b00;
  logic [1:0] ld = 2'b00;
  bit  done = 1'b0;
  int  sa [512];
  int  sb [512];
  int  sc [512];

  // {mode, disp}
  localparam logic [3:0] VEC [12] = '{
    4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0101, 4'b0110,
    4'b1000, 4'b1001, 4'b1010, 4'b0011, 4'b1100, 4'b0111
  };

  mlpwm_top #(.HALF(H)) uut (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .disp_i    (disp_i),
    .mi_i      (mi_i),
    .gate_hi_o (up),
    .gate_lo_o (dn),
    .err_o     (err)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // expected upper bits of one leg when the reference is zero
  function automatic logic [3:0] exp_leg(input logic [1:0] m, input logic [1:0] d, input int t);
    logic [3:0] r;
    int nb;
    int sz;
    nb = (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
    sz = 4 / nb;
    r  = '0;
    for (int j = 0; j < nb; j++) begin
      bit inv;
      int tj;
      int c;
      inv = (d == 2'b01) ? (j * sz * H < PER) : (d == 2'b10) ? (j % 2 == 1) : 1'b0;
      tj  = inv ? H - t : t;
      c   = j * sz * H - PER + sz * tj;
      for (int s = 0; s < sz; s++) r[j*sz+s] = (c < 0);
    end
    return r;
  endfunction

  function automatic int tri_at(input int ee);
    int k;
    k = (ee - 1) % PER;
    return (k <= H) ? k : PER - k;
  endfunction

  task automatic tick();
    @(posedge clk);
    e++;
    @(negedge clk);
  endtask

  task automatic latch_update();
    if (e % PER == 0) begin
      lm = mode_i;
      ld = disp_i;
    end
  endtask

  task automatic run_checked(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [11:0] xu;
      logic        xe;
      tick();
      if (e == 0) begin
        xu = '0; xe = 1'b0;
      end else if (lm == 2'b11) begin
        xu = '0; xe = 1'b1;
      end else begin
        xu = {3{exp_leg(lm, ld, tri_at(e))}};
        xe = 1'b0;
      end
      chk(up == xu, tag, 32'(up), 32'(xu));
      chk(dn == ~xu, tag, 32'(dn), 32'(~xu));
      chk(err == xe, tag, 32'(err), 32'(xe));
      latch_update();
    end
  endtask

  function automatic string tag_of(input logic [3:0] v);
    if (v[3:2] == 2'b11) return "R8/R7";
    if (v[1:0] != 2'b00) return "R6/R5/R7";
    if (v[3:2] == 2'b00) return "R2/R5/R7";
    if (v[3:2] == 2'b01) return "R3/R5/R7";
    return "R4/R5/R7";
  endfunction

  task automatic check_reset_state();
    chk(up == '0, "R1 upper", 32'(up), 0);
    chk(dn == '1, "R1 lower", 32'(dn), 32'hfff);
    chk(err == 1'b0, "R1 err", 32'(err), 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      sa[i] = 0; sb[i] = 0; sc[i] = 0;
    end
    // R1: reset state
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check_reset_state();
    end

    // table walk with zero reference
    mode_i = VEC[0][3:2];
    disp_i = VEC[0][1:0];
    rst = 1'b0;
    e = -1;
    for (int v = 0; v < 12; v++) begin
      mode_i = VEC[v][3:2];
      disp_i = VEC[v][1:0];
      run_checked(2 * PER + 7, tag_of(VEC[v]));
    end

    // R1: reset taken mid-run, with an error pending
    mode_i = 2'b11;
    run_checked(2 * PER, "R8");
    rst = 1'b1;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      check_reset_state();
    end

    // full-index sine sweep, five-level, in phase
    mode_i = 2'b00;
    disp_i = 2'b00;
    mi_i   = 8'd255;
    rst    = 1'b0;
    e      = -1;
    lm     = 2'b00;
    ld     = 2'b00;
    for (int i = 0; i < PER * NPER_SWEEP + 1; i++) begin
      tick();
      if (e >= 1) begin
        int p;
        p = (e - 1) / PER;
        sa[p] += $countones(up[3:0]);
        sb[p] += $countones(up[7:4]);
        sc[p] += $countones(up[11:8]);
        for (int ph = 0; ph < 3; ph++) begin
          logic [3:0] g;
          g = up[ph*4 +: 4];
          // R5: stack order within a leg
          chk((g == 4'b0000) || (g == 4'b0001) || (g == 4'b0011) || (g == 4'b0111) || (g == 4'b1111),
              "R5 stack order", 32'(g), 32'(g));
          chk(dn[ph*4 +: 4] == ~g, "R2 complement", 32'(dn[ph*4 +: 4]), 32'(~g));
        end
      end
      latch_update();
    end

    // R9: zero crossing at step 0 and phase offsets
    chk(sa[0] == 59, "R9 phase A step 0", 32'(sa[0]), 59);
    for (int p = 0; p < 256; p++) begin
      chk(sb[p] == sa[p+85], "R9 phase B offset", 32'(sb[p]), 32'(sa[p+85]));
      chk(sc[p] == sa[p+171], "R9 phase C offset", 32'(sc[p]), 32'(sa[p+171]));
    end
    // R10: full swing
    chk(sa[192] == 0, "R10 trough", 32'(sa[192]), 0);
    chk(sa[64] == 117, "R10 crest", 32'(sa[64]), 117);

    // grouping with a moving reference
    mode_i = 2'b01;
    mi_i   = 8'd200;
    for (int i = 0; i < 4 * PER; i++) begin
      tick();
      for (int ph = 0; ph < 3; ph++) begin
        logic [3:0] g;
        g = up[ph*4 +: 4];
        if (lm == 2'b01)
          chk((g[0] == g[1]) && (g[2] == g[3]), "R3 pairs", 32'(g), 32'(g));
      end
      latch_update();
    end
    mode_i = 2'b10;
    disp_i = 2'b10;
    for (int i = 0; i < 4 * PER; i++) begin
      tick();
      for (int ph = 0; ph < 3; ph++) begin
        logic [3:0] g;
        g = up[ph*4 +: 4];
        if (lm == 2'b10)
          chk((g == 4'b0000) || (g == 4'b1111), "R4 quad", 32'(g), 32'(g));
      end
      latch_update();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

endmodule